// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block takes one instruction word per strobe, together with the address of that word and the processor status word. It reports whether the word encodes a conditional relative jump and whether that jump is taken, and it returns the address of the next instruction. Both paths first step the address forward by one instruction word (two bytes). A taken branch then adds a signed word displacement, doubled to make a byte distance, to that stepped address.

The unit sits between instruction decode and the fetch address mux. It has no memory and no side effects. Outputs are registered and appear one clock after the strobe, and they hold their last values between strobes. Fetch, status register updates and all other instruction classes are handled elsewhere.

Top module: `branch_unit`

## Requirements
- R1: `is_jump_o` is 1 exactly when bits 15:13 of the captured word equal 3'b001.
- R2: Only status bits 0 (carry), 1 (zero), 2 (negative) and 8 (overflow) affect the decision. All other status bits are ignored.
- R3: Condition field (bits 12:10) value 0 branches when zero is clear, and value 1 branches when zero is set.
- R4: Condition value 2 branches when carry is clear, and value 3 branches when carry is set.
- R5: Condition value 4 branches when negative is set, whatever the overflow bit holds.
- R6: Condition value 5 branches when negative equals overflow, and value 6 branches when they differ.
- R7: Condition value 7 branches unconditionally.
- R8: A taken branch gives next_pc = pc + 2 + 2*d, where d is bits 9:0 sign-extended from bit 9 (range -512..511).
- R9: A non-jump word, or a jump whose condition fails, gives next_pc = pc + 2.
- R10: All address arithmetic wraps modulo 2^16.
- R11: `valid_o` is high exactly in the cycle after each `valid_i` strobe. Without a strobe, the other outputs hold their values.
- R12: `taken_o` is never 1 unless `is_jump_o` is 1. The condition field of a non-jump word has no effect.
- R13: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Strobe: inputs hold an instruction to evaluate |
| opcode_i | input | 16 | Instruction word |
| pc_i | input | 16 | Byte address of the instruction word |
| status_i | input | 16 | Processor status word |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| is_jump_o | output | 1 | Word is a conditional relative jump |
| taken_o | output | 1 | Jump condition holds |
| next_pc_o | output | 16 | Address of the next instruction |

## Verification
On every cycle, assertions check the strobe timing, the holding of outputs between strobes, the jump-class flag against the captured word, the rule that a taken branch is always a jump, the fall-through address for non-jumps, and the unconditional code. Only the bench scenarios show the flag-dependent decisions for each condition code, which status bits are ignored, the extreme displacements and the address wrap at both ends of the 16-bit space. The bench compares each of these against a behavioural model.

// File: rtl/branch_pkg.sv
package branch_pkg;
  localparam int ADDR_W   = 16;
  localparam int INSTR_W  = 16;
  localparam int COND_W   = 3;
  localparam int OFF_W    = 10;
  localparam int CLASS_W  = INSTR_W - COND_W - OFF_W;
  localparam int STEP     = 2;
  localparam logic [CLASS_W-1:0] JUMP_CLASS = 3'b001;

  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 8;

  typedef enum logic [COND_W-1:0] {
    CND_NZ   = 3'd0,
    CND_Z    = 3'd1,
    CND_NC   = 3'd2,
    CND_C    = 3'd3,
    CND_NEG  = 3'd4,
    CND_GE   = 3'd5,
    CND_LT   = 3'd6,
    CND_ALW  = 3'd7
  } cond_e;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } flags_t;
endpackage

// File: rtl/branch_decode.sv
module branch_decode
  import branch_pkg::*;
(
  input  logic [INSTR_W-1:0] opcode_i,
  output logic               is_jump_o,
  output cond_e              cond_o,
  output logic [OFF_W-1:0]   off_o
);
  localparam int CLASS_LSB = COND_W + OFF_W;

  assign is_jump_o = (opcode_i[INSTR_W-1:CLASS_LSB] == JUMP_CLASS);
  assign cond_o    = cond_e'(opcode_i[CLASS_LSB-1:OFF_W]);
  assign off_o     = opcode_i[OFF_W-1:0];
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
  import branch_pkg::*;
#(
  parameter int SR_W = 16
) (
  input  logic [SR_W-1:0] status_i,
  input  cond_e           cond_i,
  output logic            hit_o
);
  flags_t fl;
  assign fl = '{c: status_i[FLAG_C], z: status_i[FLAG_Z],
                n: status_i[FLAG_N], v: status_i[FLAG_V]};

  always_comb begin
    unique case (cond_i)
      CND_NZ:  hit_o = ~fl.z;
      CND_Z:   hit_o =  fl.z;
      CND_NC:  hit_o = ~fl.c;
      CND_C:   hit_o =  fl.c;
      CND_NEG: hit_o =  fl.n;
      CND_GE:  hit_o = ~(fl.n ^ fl.v);
      CND_LT:  hit_o =  (fl.n ^ fl.v);
      default: hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/branch_target.sv
module branch_target
  import branch_pkg::*;
(
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              take_i,
  output logic [ADDR_W-1:0] next_pc_o
);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] seq_pc, disp;

  assign seq_pc = pc_i + ADDR_W'(STEP);

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp = {{(EXT_W-1){off_i[OFF_W-1]}}, off_i, 1'b0};
    end else begin : g_trunc
      assign disp = {off_i[ADDR_W-2:0], 1'b0};
    end
  endgenerate

  // wraps modulo 2^ADDR_W
  assign next_pc_o = take_i ? seq_pc + disp : seq_pc;
endmodule

// File: rtl/branch_unit.sv
module branch_unit
  import branch_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] opcode_i,
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic [15:0]        status_i,
  output logic               valid_o,
  output logic               is_jump_o,
  output logic               taken_o,
  output logic [ADDR_W-1:0]  next_pc_o
);
  logic             dec_jump, cond_hit, take;
  cond_e            dec_cond;
  logic [OFF_W-1:0] dec_off;
  logic [ADDR_W-1:0] nxt;

  branch_decode u_dec (
    .opcode_i (opcode_i),
    .is_jump_o(dec_jump),
    .cond_o   (dec_cond),
    .off_o    (dec_off)
  );

  branch_cond_eval #(.SR_W(16)) u_cond (
    .status_i(status_i),
    .cond_i  (dec_cond),
    .hit_o   (cond_hit)
  );

  assign take = dec_jump & cond_hit;

  branch_target u_tgt (
    .pc_i     (pc_i),
    .off_i    (dec_off),
    .take_i   (take),
    .next_pc_o(nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      is_jump_o <= 1'b0;
      taken_o   <= 1'b0;
      next_pc_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        is_jump_o <= dec_jump;
        taken_o   <= take;
        next_pc_o <= nxt;
      end
    end
  end

  // R11
  valid_echo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R11
  no_spurious_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(next_pc_o) && $stable(taken_o) && $stable(is_jump_o)));
  // R1
  jump_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (is_jump_o == ($past(opcode_i[15:13]) == 3'b001)));
  // R12
  taken_needs_jump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> is_jump_o);
  // R9
  fallthrough_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i[15:13] != 3'b001) |=>
      (next_pc_o == $past(pc_i) + 16'd2 && !taken_o));
  // R7
  always_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i[15:10] == 6'b001111) |=> taken_o);
endmodule

// File: tb/branch_unit_bench.sv
module branch_unit_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] opcode_i = '0, pc_i = '0, status_i = '0;
  logic        valid_o, is_jump_o, taken_o;
  logic [15:0] next_pc_o;

  int checks = 0, errors = 0;
  bit done = 0;

  bit          e_valid = 0, e_jump = 0, e_taken = 0;
  logic [15:0] e_pc = '0;
  string       e_tag = "R13";

  always #4 clk = ~clk;

  branch_unit u_branch_unit (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .opcode_i(opcode_i),
    .pc_i(pc_i), .status_i(status_i), .valid_o(valid_o),
    .is_jump_o(is_jump_o), .taken_o(taken_o), .next_pc_o(next_pc_o)
  );

  function automatic void model(input logic [15:0] op, pc, sr,
                                output bit j, output bit t, output logic [15:0] npc);
    int cc, d, a;
    bit c, z, n, v;
    j  = (op >> 13) == 1;
    cc = (op >> 10) & 7;
    c = sr[0]; z = sr[1]; n = sr[2]; v = sr[8];
    case (cc)
      0: t = !z;
      1: t = z;
      2: t = !c;
      3: t = c;
      4: t = n;
      5: t = (n == v);
      6: t = (n != v);
      default: t = 1;
    endcase
    t = t && j;
    d = op & 'h3FF;
    if (d >= 512) d = d - 1024;
    a = int'(pc) + 2 + (t ? 2 * d : 0);
    npc = 16'(a & 'hFFFF);
  endfunction

  function automatic logic [15:0] mk(int cc, int off);
    return 16'('h2000 | ((cc & 7) << 10) | (off & 'h3FF));
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_now();
    chk("R11", "valid_o", int'(valid_o), int'(e_valid));
    chk(e_tag, "is_jump_o", int'(is_jump_o), int'(e_jump));
    chk(e_tag, "taken_o", int'(taken_o), int'(e_taken));
    chk(e_tag, "next_pc_o", int'(next_pc_o), int'(e_pc));
  endtask

  task automatic step(bit v, logic [15:0] op, pc, sr, string tag);
    bit j, t;
    logic [15:0] np;
    @(negedge clk);
    compare_now();
    valid_i = v; opcode_i = op; pc_i = pc; status_i = sr;
    e_valid = v;
    if (v) begin
      model(op, pc, sr, j, t, np);
      e_jump = j; e_taken = t; e_pc = np; e_tag = tag;
    end else begin
      e_tag = "R11";
    end
  endtask

  initial begin
    #(8 * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    compare_now();
    rst_ni = 1'b1;
    // R3
    step(1, mk(0, 5), 16'h0100, 16'h0000, "R3");
    step(1, mk(0, 5), 16'h0100, 16'h0002, "R3");
    step(1, mk(1, 5), 16'h0100, 16'h0002, "R3");
    step(1, mk(1, 5), 16'h0100, 16'h0000, "R3");
    // R4
    step(1, mk(2, 7), 16'h0200, 16'h0000, "R4");
    step(1, mk(2, 7), 16'h0200, 16'h0001, "R4");
    step(1, mk(3, 7), 16'h0200, 16'h0001, "R4");
    step(1, mk(3, 7), 16'h0200, 16'h0000, "R4");
    // R5
    step(1, mk(4, 9), 16'h0300, 16'h0004, "R5");
    step(1, mk(4, 9), 16'h0300, 16'h0100, "R5");
    step(1, mk(4, 9), 16'h0300, 16'h0104, "R5");
    // R6
    for (int k = 0; k < 4; k++) begin
      logic [15:0] sr = 16'((k[0] ? 'h4 : 0) | (k[1] ? 'h100 : 0));
      step(1, mk(5, 3), 16'h0400, sr, "R6");
      step(1, mk(6, 3), 16'h0400, sr, "R6");
    end
    // R7
    step(1, mk(7, 1), 16'h0500, 16'h0000, "R7");
    step(1, mk(7, 1), 16'h0500, 16'hFFFF, "R7");
    // R2: non-flag bits set, flags clear
    step(1, mk(1, 4), 16'h0600, 16'hFEF8, "R2");
    step(1, mk(3, 4), 16'h0600, 16'hFEF8, "R2");
    step(1, mk(4, 4), 16'h0600, 16'hFEF8, "R2");
    step(1, mk(6, 4), 16'h0600, 16'hFEF8, "R2");
    step(1, mk(5, 4), 16'h0600, 16'hFEF8, "R2");
    // R8 extreme displacements
    step(1, mk(7, 'h1FF), 16'h4000, 16'h0000, "R8");
    step(1, mk(7, 'h200), 16'h4000, 16'h0000, "R8");
    step(1, mk(7, 'h3FF), 16'h4000, 16'h0000, "R8");
    // R10 wrap
    step(1, mk(7, 0), 16'hFFFE, 16'h0000, "R10");
    step(1, mk(7, 'h10), 16'hFFF0, 16'h0000, "R10");
    step(1, mk(7, 'h200), 16'h0004, 16'h0000, "R10");
    // R9 / R12 non-jumps with condition bits set
    step(1, 16'h5C05, 16'h0700, 16'hFFFF, "R12");
    step(1, 16'h1C05, 16'h0700, 16'hFFFF, "R12");
    step(1, 16'hFFFF, 16'h0700, 16'hFFFF, "R9");
    step(1, 16'h4130, 16'hFFFE, 16'h0000, "R9");
    // R11 gaps and hold
    step(0, mk(7, 'h55), 16'h1234, 16'h0000, "R11");
    step(0, 16'h0000, 16'h0000, 16'h0000, "R11");
    step(1, mk(7, 'h55), 16'h1234, 16'h0000, "R11");
    step(1, mk(0, 2), 16'h1234, 16'h0002, "R11");
    // R1 random sweep
    for (int i = 0; i < 400; i++) begin
      logic [15:0] op = 16'($urandom);
      if (i % 2 == 0) op = {3'b001, op[12:0]};
      step(($urandom % 4) != 0, op, 16'($urandom), 16'($urandom), "R1");
    end
    step(0, 16'h0, 16'h0, 16'h0, "R11");
    step(0, 16'h0, 16'h0, 16'h0, "R11");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule